// File: doc/BRIEF.md
# Script Engine Transfer-Control Unit

This unit carries out the flow-control instructions of a small script engine that sequences a peripheral bus controller. These are jump, call, return, a halting interrupt and a non-halting interrupt. Each cycle in which `exec_valid` is high presents one decoded 32-bit instruction word and its 32-bit address word. The unit evaluates the instruction's condition from three sources: the ALU carry, a bus phase captured on the request strobe, and a data byte. It then updates the instruction pointer, the single-entry return register, the interrupt vector register, the interrupt request, the on-the-fly status flag and the halt state.

Instruction fetch, memory, the ALU and bus phase sequencing sit outside the unit. The pointer value it holds is the address of the next fetch. A host side can reload the pointer, which restarts a halted engine. It can also clear the two interrupt indications with one strobe each.

Top module: `tcu_xfer_ctl`

## Requirements
- R1: After reset, `ip`, `ret_addr` and `int_vector` are 0, and `irq`, `fly_flag` and `halted` are 0.
- R2: The opcode sits in instruction bits [29:27]: 0 jump, 1 call, 2 return, 3 interrupt, 4 on-the-fly interrupt. Bit 16 enables the carry test, bit 17 the phase test and bit 18 the data test. If bit 16 is set, the match is `alu_carry` and the other tests are ignored. Otherwise the match is the AND of the enabled phase and data tests. Bit 21 set means act on match, clear means act on mismatch. With none of bits 16..18 set, the instruction is always taken.
- R3: The data test compares `bus_data` with the reference in bits [7:0] under the mask in bits [15:8]. A mask bit of 1 excludes that bit from the test.
- R4: `bus_phase` is captured into an internal latch on cycles with `req_strobe` high. The phase test compares that latch with bits [26:24]. An instruction executed in the same cycle as a strobe sees the previously latched phase.
- R5: An instruction that is not taken advances `ip` by 8 and changes no other output.
- R6: A taken jump loads `ip` with `addr_word` and leaves `ret_addr` unchanged.
- R7: A taken call writes `ip + 8` into `ret_addr` and loads `ip` with `addr_word`.
- R8: A taken return copies `ret_addr` into `ip`, whether or not a call preceded it, and raises neither `irq` nor `halted`.
- R9: A taken interrupt sets `irq` and `halted`, stores `addr_word` in `int_vector`, and advances `ip` by 8.
- R10: While `halted` is high, `exec_valid` has no effect on any output. `host_ip_we` loads `ip` from `host_ip_data` and clears `halted` one cycle later. When `host_ip_we` and `exec_valid` are both high in the same cycle, the host write wins and the instruction is dropped.
- R11: A taken on-the-fly interrupt sets `fly_flag` (status bit 2), advances `ip` by 8 and does not halt.
- R12: `clr_irq` clears `irq` and `clr_fly` clears `fly_flag`. Both flags otherwise hold. A set in the same cycle as a clear leaves the flag set.
- R13: Opcodes 5 to 7 only advance `ip` by 8, whatever the condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Decoded instruction word |
| addr_word | input | 32 | Target / vector address word |
| alu_carry | input | 1 | ALU carry flag |
| bus_phase | input | 3 | Bus phase lines |
| req_strobe | input | 1 | Request strobe, captures `bus_phase` |
| bus_data | input | 8 | Data byte for the data test |
| host_ip_we | input | 1 | Host write to the pointer |
| host_ip_data | input | 32 | Value for the host pointer write |
| clr_irq | input | 1 | Clear interrupt request |
| clr_fly | input | 1 | Clear on-the-fly status flag |
| ip | output | 32 | Instruction pointer (next fetch address) |
| ret_addr | output | 32 | Return address register |
| int_vector | output | 32 | Saved interrupt vector |
| irq | output | 1 | Interrupt request |
| fly_flag | output | 1 | On-the-fly interrupt status (bit 2) |
| halted | output | 1 | Engine halted |

## Verification
Two collisions matter most. The first is a taken interrupt or on-the-fly interrupt in the same cycle as the host strobe that clears the same flag. The second is a host pointer write arriving together with an executed instruction. Directed steps create both collisions on purpose, and the random stream also hits them, since clear strobes and host writes are drawn every cycle independently of the instruction. In each case the flag must end up set, the instruction must be dropped in favour of the host value, and this is compared against the bench's own step model on every output.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int INSTR_W = 32;

  // opcode field and values
  localparam int OP_LO = 27;
  localparam logic [2:0] OP_JUMP = 3'd0;
  localparam logic [2:0] OP_CALL = 3'd1;
  localparam logic [2:0] OP_RET  = 3'd2;
  localparam logic [2:0] OP_INT  = 3'd3;
  localparam logic [2:0] OP_FLY  = 3'd4;

  // condition field positions
  localparam int PH_LO  = 24;
  localparam int TF_BIT = 21;
  localparam int ED_BIT = 18;
  localparam int EP_BIT = 17;
  localparam int EC_BIT = 16;
  localparam int MSK_LO = 8;
  localparam int REF_LO = 0;

  // masked byte equality: mask bit 1 ignores that bit
  function automatic logic byte_match(input logic [7:0] data,
                                      input logic [7:0] refv,
                                      input logic [7:0] mask);
    return ((data ^ refv) & ~mask) == 8'h00;
  endfunction

  // pointer arithmetic kept in one place
  function automatic logic [31:0] next_seq(input logic [31:0] ptr,
                                           input int unsigned step);
    return ptr + step;
  endfunction
endpackage

// File: rtl/tcu_cond.sv
module tcu_cond
  import tcu_pkg::*;
(
  input  logic [2:0] exp_phase,
  input  logic       act_on_true,
  input  logic       en_carry,
  input  logic       en_phase,
  input  logic       en_data,
  input  logic [7:0] data_mask,
  input  logic [7:0] data_ref,
  input  logic       carry,
  input  logic [2:0] phase_lat,
  input  logic [7:0] data_in,
  output logic       taken
);
  logic phase_ok, data_ok, matched, any_en;

  always_comb begin
    phase_ok = !en_phase || (phase_lat == exp_phase);
    data_ok  = !en_data  || byte_match(data_in, data_ref, data_mask);
    matched  = en_carry ? carry : (phase_ok && data_ok);
    any_en   = en_carry || en_phase || en_data;
    taken    = !any_en || (matched == act_on_true);
  end
endmodule

// File: rtl/tcu_flags.sv
module tcu_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_irq,
  input  logic set_fly,
  input  logic clr_irq,
  input  logic clr_fly,
  output logic irq,
  output logic fly_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      fly_flag <= 1'b0;
    end else begin
      irq      <= set_irq || (irq && !clr_irq);
      fly_flag <= set_fly || (fly_flag && !clr_fly);
    end
  end
endmodule

// File: rtl/tcu_xfer_ctl.sv
module tcu_xfer_ctl
  import tcu_pkg::*;
#(
  parameter int AW          = 32,
  parameter int INSTR_BYTES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exec_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [AW-1:0]       addr_word,
  input  logic                alu_carry,
  input  logic [2:0]          bus_phase,
  input  logic                req_strobe,
  input  logic [7:0]          bus_data,
  input  logic                host_ip_we,
  input  logic [AW-1:0]       host_ip_data,
  input  logic                clr_irq,
  input  logic                clr_fly,
  output logic [AW-1:0]       ip,
  output logic [AW-1:0]       ret_addr,
  output logic [AW-1:0]       int_vector,
  output logic                irq,
  output logic                fly_flag,
  output logic                halted
);
  localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

  logic [2:0]    phase_lat;
  logic [2:0]    op;
  logic          cond_taken;
  logic          exec_go;
  logic          set_irq, set_fly;
  logic [AW-1:0] seq_ip;
  logic          unused_bits;

  assign op          = instr[OP_LO +: 3];
  assign unused_bits = ^{instr[31:30], instr[23:22], instr[20:19]};
  assign exec_go     = exec_valid && !halted && !host_ip_we;
  assign seq_ip      = ip + STEP;
  assign set_irq     = exec_go && cond_taken && (op == OP_INT);
  assign set_fly     = exec_go && cond_taken && (op == OP_FLY);

  always_ff @(posedge clk) begin
    if (!rst_n)          phase_lat <= 3'd0;
    else if (req_strobe) phase_lat <= bus_phase;
  end

  tcu_cond i_cond (
    .exp_phase   (instr[PH_LO +: 3]),
    .act_on_true (instr[TF_BIT]),
    .en_carry    (instr[EC_BIT]),
    .en_phase    (instr[EP_BIT]),
    .en_data     (instr[ED_BIT]),
    .data_mask   (instr[MSK_LO +: 8]),
    .data_ref    (instr[REF_LO +: 8]),
    .carry       (alu_carry),
    .phase_lat   (phase_lat),
    .data_in     (bus_data),
    .taken       (cond_taken)
  );

  tcu_flags i_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_irq  (set_irq),
    .set_fly  (set_fly),
    .clr_irq  (clr_irq),
    .clr_fly  (clr_fly),
    .irq      (irq),
    .fly_flag (fly_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip         <= '0;
      ret_addr   <= '0;
      int_vector <= '0;
      halted     <= 1'b0;
    end else if (host_ip_we) begin
      ip     <= host_ip_data;
      halted <= 1'b0;
    end else if (exec_go) begin
      if (!cond_taken) begin
        ip <= seq_ip;
      end else begin
        case (op)
          OP_JUMP: ip <= addr_word;
          OP_CALL: begin
            ret_addr <= seq_ip;
            ip       <= addr_word;
          end
          OP_RET:  ip <= ret_addr;
          OP_INT: begin
            int_vector <= addr_word;
            halted     <= 1'b1;
            ip         <= seq_ip;
          end
          default: ip <= seq_ip;
        endcase
      end
    end
  end
endmodule

// File: rtl/tcu_xfer_chk.sv
module tcu_xfer_chk
  import tcu_pkg::*;
#(
  parameter int AW          = 32,
  parameter int INSTR_BYTES = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_ip_we,
  input logic          clr_irq,
  input logic          clr_fly,
  input logic [AW-1:0] addr_word,
  input logic [AW-1:0] ip,
  input logic [AW-1:0] ret_addr,
  input logic [AW-1:0] int_vector,
  input logic          irq,
  input logic          fly_flag,
  input logic          halted,
  input logic          exec_go,
  input logic          cond_taken,
  input logic [2:0]    op
);
  localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

  // R5
  no_take_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && !cond_taken |=> ip == $past(ip) + STEP);

  // R7
  call_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && cond_taken && op == OP_CALL |=> ret_addr == $past(ip) + STEP && ip == $past(addr_word));

  // R8
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && cond_taken && op == OP_RET |=> ip == $past(ret_addr) && !halted);

  // R9
  int_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && cond_taken && op == OP_INT |=> irq && halted && int_vector == $past(addr_word));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !host_ip_we |=> $stable(ip) && halted);

  // R10
  host_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ip_we |=> !halted);

  // R11
  fly_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && cond_taken && op == OP_FLY |=> fly_flag && !halted);

  // R12
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq && !(exec_go && cond_taken && op == OP_INT) |=> !irq);

  // R12
  fly_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fly && !(exec_go && cond_taken && op == OP_FLY) |=> !fly_flag);
endmodule

bind tcu_xfer_ctl tcu_xfer_chk #(.AW(AW), .INSTR_BYTES(INSTR_BYTES)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ip_we (host_ip_we),
  .clr_irq    (clr_irq),
  .clr_fly    (clr_fly),
  .addr_word  (addr_word),
  .ip         (ip),
  .ret_addr   (ret_addr),
  .int_vector (int_vector),
  .irq        (irq),
  .fly_flag   (fly_flag),
  .halted     (halted),
  .exec_go    (exec_go),
  .cond_taken (cond_taken),
  .op         (op)
);

// File: tb/test_tcu_xfer_ctl.sv
`timescale 1ns/1ps
module test_tcu_xfer_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] addr_word = '0;
  logic        alu_carry = 1'b0;
  logic [2:0]  bus_phase = '0;
  logic        req_strobe = 1'b0;
  logic [7:0]  bus_data = '0;
  logic        host_ip_we = 1'b0;
  logic [31:0] host_ip_data = '0;
  logic        clr_irq = 1'b0;
  logic        clr_fly = 1'b0;
  logic [31:0] ip, ret_addr, int_vector;
  logic        irq, fly_flag, halted;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side model state
  logic [31:0] m_ip = 0, m_ret = 0, m_vec = 0;
  logic        m_irq = 0, m_fly = 0, m_halt = 0;
  logic [2:0]  m_phase = 0;

  always #4 clk = ~clk;

  tcu_xfer_ctl i_tcu_xfer_ctl (
    .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .instr(instr),
    .addr_word(addr_word), .alu_carry(alu_carry), .bus_phase(bus_phase),
    .req_strobe(req_strobe), .bus_data(bus_data), .host_ip_we(host_ip_we),
    .host_ip_data(host_ip_data), .clr_irq(clr_irq), .clr_fly(clr_fly),
    .ip(ip), .ret_addr(ret_addr), .int_vector(int_vector), .irq(irq),
    .fly_flag(fly_flag), .halted(halted)
  );

  function automatic logic [31:0] mk(input int op, input bit tf, input bit ec,
                                     input bit ep, input bit ed, input int ph,
                                     input int mask, input int rv);
    logic [31:0] w = '0;
    w[29:27] = op[2:0];
    w[26:24] = ph[2:0];
    w[21] = tf; w[18] = ed; w[17] = ep; w[16] = ec;
    w[15:8] = mask[7:0];
    w[7:0] = rv[7:0];
    return w;
  endfunction

  // condition restated bit by bit from R2..R4
  function automatic bit b_taken(input logic [31:0] w, input bit cy,
                                 input logic [2:0] ph, input logic [7:0] d);
    bit m = 1;
    if (!w[16] && !w[17] && !w[18]) return 1;
    if (w[16]) m = cy;
    else begin
      if (w[17] && ph != w[26:24]) m = 0;
      if (w[18])
        for (int i = 0; i < 8; i++)
          if (!w[8+i] && d[i] != w[i]) m = 0;
    end
    return w[21] ? m : !m;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "ip", ip, m_ip);
    chk(tag, "ret_addr", ret_addr, m_ret);
    chk(tag, "int_vector", int_vector, m_vec);
    chk(tag, "irq", {31'b0, irq}, {31'b0, m_irq});
    chk(tag, "fly_flag", {31'b0, fly_flag}, {31'b0, m_fly});
    chk(tag, "halted", {31'b0, halted}, {31'b0, m_halt});
  endtask

  // called at a negedge: drive, model, clock, compare
  task automatic step(input string tag_in, input bit ev, input logic [31:0] w,
                      input logic [31:0] aw, input bit cy, input logic [2:0] bp,
                      input bit rs, input logic [7:0] bd, input bit hw,
                      input logic [31:0] hd, input bit ci, input bit cf);
    bit go, t;
    string tag;
    int op;
    logic [31:0] seq;
    exec_valid = ev; instr = w; addr_word = aw; alu_carry = cy;
    bus_phase = bp; req_strobe = rs; bus_data = bd; host_ip_we = hw;
    host_ip_data = hd; clr_irq = ci; clr_fly = cf;
    go = ev && !m_halt && !hw;
    t = b_taken(w, cy, m_phase, bd);
    op = int'(w[29:27]);
    seq = m_ip + 32'd8;
    tag = "R12";
    m_irq = (go && t && op == 3) || (m_irq && !ci);
    m_fly = (go && t && op == 4) || (m_fly && !cf);
    if (hw) begin
      m_ip = hd; m_halt = 0; tag = "R10";
    end else if (go) begin
      if (!t) begin m_ip = seq; tag = "R5"; end
      else begin
        case (op)
          0: begin m_ip = aw; tag = "R6"; end
          1: begin m_ret = seq; m_ip = aw; tag = "R7"; end
          2: begin m_ip = m_ret; tag = "R8"; end
          3: begin m_vec = aw; m_halt = 1; m_ip = seq; tag = "R9"; end
          4: begin m_ip = seq; tag = "R11"; end
          default: begin m_ip = seq; tag = "R13"; end
        endcase
      end
    end else if (ev) tag = "R10";
    if (rs) m_phase = bp;
    if (tag_in != "") tag = tag_in;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle();
    step("", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1");

    // R8: return with no prior call restores the zero return register
    step("R8", 1, mk(2,0,0,0,0,0,0,0), 32'h40, 0,0,0,0, 0,0,0,0);
    // R7: call saves ip+8
    step("R7", 1, mk(1,0,0,0,0,0,0,0), 32'h100, 0,0,0,0, 0,0,0,0);
    // R2: carry test act-on-true, carry 1 taken; carry 0 not taken; act-on-false taken
    step("R2", 1, mk(0,1,1,0,0,0,0,0), 32'h200, 1,0,0,0, 0,0,0,0);
    step("R2", 1, mk(0,1,1,1,0,7,0,0), 32'h300, 0,0,0,0, 0,0,0,0);
    step("R2", 1, mk(0,0,1,0,0,0,0,0), 32'h300, 0,0,0,0, 0,0,0,0);
    // R4: latch phase 5, then match; strobe 2 same cycle still sees 5
    step("R4", 0, 0, 0, 0, 3'd5, 1, 0, 0,0,0,0);
    step("R4", 1, mk(0,1,0,1,0,5,0,0), 32'h500, 0,0,0,0, 0,0,0,0);
    step("R4", 1, mk(0,1,0,1,0,2,0,0), 32'h600, 0,3'd2,1,0, 0,0,0,0);
    // R3: masked data compare
    step("R3", 1, mk(0,1,0,0,1,0,8'h0F,8'hA3), 32'h700, 0,0,0,8'hA9, 0,0,0,0);
    step("R3", 1, mk(0,1,0,0,1,0,8'h0F,8'hA3), 32'h800, 0,0,0,8'hB3, 0,0,0,0);
    // R9 then R10: halt, ignored exec, host write with simultaneous exec
    step("R9", 1, mk(3,0,0,0,0,0,0,0), 32'hCAFE_0001, 0,0,0,0, 0,0,0,0);
    step("R10", 1, mk(0,0,0,0,0,0,0,0), 32'h900, 0,0,0,0, 0,0,0,0);
    step("R10", 1, mk(0,0,0,0,0,0,0,0), 32'h900, 0,0,0,0, 1,32'h1000,0,0);
    // R12: interrupt set with clear in the same cycle keeps the flag, then clear
    step("R12", 1, mk(3,0,0,0,0,0,0,0), 32'hBEEF, 0,0,0,0, 0,0,1,0);
    step("R12", 0, 0, 0, 0,0,0,0, 1,32'h2000,1,0);
    // R11: on-the-fly, with clear in the same cycle
    step("R11", 1, mk(4,0,0,0,0,0,0,0), 0, 0,0,0,0, 0,0,0,1);
    idle();
    step("R12", 0, 0, 0, 0,0,0,0, 0,0,0,1);
    // R13: undefined opcode advances
    step("R13", 1, mk(6,0,0,0,0,0,0,0), 32'h4444, 0,0,0,0, 0,0,0,0);

    // constrained random stream
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 10);
      int op = (r < 8) ? int'($urandom % 5) : 5 + int'($urandom % 3);
      logic [7:0] rv = 8'($urandom);
      logic [7:0] bd = ($urandom % 2) ? rv : 8'($urandom);
      logic [31:0] w = mk(op, 1'($urandom), ($urandom % 4) == 0,
                          1'($urandom), 1'($urandom), int'($urandom % 8),
                          ($urandom % 2) ? int'($urandom % 256) : 0, int'(rv));
      bit hw = m_halt ? ($urandom % 4) == 0 : ($urandom % 20) == 0;
      step("", ($urandom % 10) < 7, w, {$urandom} & 32'hFFFF_FFF8,
           1'($urandom), 3'($urandom), ($urandom % 3) == 0, bd,
           hw, {$urandom} & 32'hFFFF_FFF8, ($urandom % 6) == 0,
           ($urandom % 6) == 0);
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule